// File: doc/BRIEF.md
# Keypad matrix scan controller

This block scans a 3-column by 5-row key matrix and reports which keys are held as one bitmask. While idle it drives every column low, so that a press on any key pulls its row line low. The row lines pass through two-flop synchronizers. Two detectors watch them: a depress detector for "some row low while idle" and a release detector for "every row high while idle". Each detector sets a sticky flag on the rising edge of its condition. A flag that is set, together with its own enable, raises the interrupt output. While the block is idle, a raised interrupt starts a scan.

A scan treats columns 0, 1 and 2 in turn. All columns are driven high in push-pull mode for a discharge interval. The drivers then return to open-drain and only the current column is pulled low. After a settle interval the five rows are sampled. Every pressed position that carries a key sets its own bit in the result word. At the end of the scan the columns return low and both flags are cleared. The depress detector chain is cleared, and the release detector chain is preset so that the release flag fires. One interrupt is then armed. The choice depends on the code reported before this scan: if that code was non-zero the release interrupt is armed, otherwise the depress interrupt is armed. The new result then becomes the reported code, and a one-cycle `scan_done_o` pulse marks the update.

Software reaches the flags, the detector chains and the enables through one 10-bit write and read port. A hold input forces the reported code to zero. Reset leaves both enables set and the release chain preset, so a scan runs at once after reset.

FSM states: S_IDLE, S_DISCHARGE, S_SETTLE, S_SAMPLE, S_FINISH. The transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| T_START | S_IDLE | S_DISCHARGE | `irq_o` is high |
| T_SETTLE | S_DISCHARGE | S_SETTLE | discharge count done |
| T_SAMPLE | S_SETTLE | S_SAMPLE | settle count done |
| T_NEXT_COL | S_SAMPLE | S_DISCHARGE | column < 2 |
| T_LAST_COL | S_SAMPLE | S_FINISH | column = 2 |
| T_RETURN | S_FINISH | S_IDLE | always |

Top module: `keyscan_ctrl`

## Requirements
- R1: Rows are active-low. A key counts as pressed when its row reads 0, seen through a two-flop synchronizer, while its own column is pulled low.
- R2: For each column in the order 0, 1, 2, the block drives all columns high with `col_pushpull_o`=1 for DISCH_CYC cycles. It then drives `col_pushpull_o`=0 with only that column low for SETTLE_CYC+1 cycles, and samples the rows in the last of those cycles.
- R3: Several keys on one column are all captured in a single scan, and every pressed key is ORed into the result.
- R4: Key bit mapping:
  - column 0, rows 0..4 map to bits 0..4;
  - column 1, rows 0..1 map to bits 5..6;
  - column 2, rows 0..4 map to bits 7..11;
  - a press at a position with no key (column 1, rows 2..4) adds nothing.
- R5: While idle, all columns are driven low with `col_pushpull_o`=0. A scan starts from idle when `irq_o` is high, and starting a scan clears both enables.
- R6: On a write, `csr_wdata_i` acts as follows:
  - bit0=1 clears the depress flag, and bit1=1 clears the release flag;
  - bit2=1 clears the depress chain, and bit3=1 presets the release chain, which makes the release flag fire again;
  - bits 8 and 9 load the depress and release enables.
  `csr_rdata_o` shows the depress flag at bit0, the release flag at bit1, the depress enable at bit8 and the release enable at bit9, with the other bits 0.
- R7: At the end of a scan, the release enable is set alone if the previously reported code was non-zero. Otherwise the depress enable is set alone. The new result then replaces the reported code.
- R8: `irq_o` is high whenever (depress flag and depress enable) or (release flag and release enable).
- R9: While `hold_i` is 1, `key_code_o` reads 0. When `hold_i` returns to 0, the stored code is shown again.
- R10: Reset leaves the flags clear, the columns low and both enables set, with the release chain preset, so that one scan runs after reset without any key.
- R11: `scan_done_o` is a one-cycle pulse in the first cycle that shows a new code. `key_code_o` changes only in such a cycle or when `hold_i` changes.
- R12: Each flag sets only on a rising edge of its synchronized condition. A condition that stays true does not set its flag again after the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_n_i | input | 5 | Row lines, active low, asynchronous |
| hold_i | input | 1 | Masks the reported code while high |
| csr_we_i | input | 1 | Control and status write strobe |
| csr_wdata_i | input | 10 | Write data (flag clears, chain controls, enables) |
| csr_rdata_o | output | 10 | Flags and enables |
| col_level_o | output | 3 | Level driven on each column |
| col_pushpull_o | output | 1 | 1 = column drivers push-pull, 0 = open-drain |
| key_code_o | output | 12 | Reported key bitmask |
| scan_done_o | output | 1 | One-cycle pulse when a new code is latched |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is the arming decision. It depends on the code reported before the scan, not on the new result. The bench therefore holds a key across two scans in a row: the first scan arms depress, and the refilled depress chain starts a second scan that arms release. It then releases the key and checks that the enables return to depress only once the chain of rescans ends. The edge-only flag behaviour is reached by switching both enables off through the write port, so that no scan consumes the flags, and then clearing a flag while its condition stays true.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
    localparam int NUM_COLS = 3;
    localparam int NUM_ROWS = 5;
    localparam int CSR_W    = 10;

    // number of keys wired on a column (rows 0..n-1)
    function automatic int keys_in_col(input int c);
        return (c == 1) ? 2 : NUM_ROWS;
    endfunction

    // first code bit used by a column
    function automatic int col_base(input int c);
        int s = 0;
        for (int i = 0; i < c; i++) s += keys_in_col(i);
        return s;
    endfunction

    localparam int KEY_BITS = col_base(NUM_COLS);

    // control/status bit positions
    localparam int B_DEP_FLAG = 0;
    localparam int B_REL_FLAG = 1;
    localparam int B_DEP_CLR  = 2;
    localparam int B_REL_SET  = 3;
    localparam int B_DEP_EN   = 8;
    localparam int B_REL_EN   = 9;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DISCHARGE,
        S_SETTLE,
        S_SAMPLE,
        S_FINISH
    } scan_state_e;
endpackage

// File: rtl/keyscan_rowsync.sv
module keyscan_rowsync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
            end else begin
                meta_q <= async_i[i];
                sync_q <= meta_q;
            end
        end
        assign sync_o[i] = sync_q;
    end
endmodule

// File: rtl/keyscan_seq.sv
module keyscan_seq
    import keyscan_pkg::*;
#(
    parameter int DISCH_CYC  = 256,
    parameter int SETTLE_CYC = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ROWS-1:0] row_sync,
    input  logic                irq,
    output logic [NUM_COLS-1:0] col_level,
    output logic                col_pushpull,
    output logic [KEY_BITS-1:0] code_q,
    output logic                scan_start,
    output logic                scan_end,
    output logic                arm_release,
    output logic                idle,
    output logic                scan_done
);
    localparam int MAXW = (DISCH_CYC > SETTLE_CYC) ? DISCH_CYC : SETTLE_CYC;
    localparam int CW   = $clog2(MAXW + 1);
    localparam int COLW = $clog2(NUM_COLS + 1);
    localparam logic [CW-1:0]   DISCH_LAST  = CW'(DISCH_CYC - 1);
    localparam logic [CW-1:0]   SETTLE_LAST = CW'(SETTLE_CYC - 1);
    localparam logic [COLW-1:0] COL_LAST    = COLW'(NUM_COLS - 1);

    scan_state_e state, state_nx;
    logic [CW-1:0]       cnt;
    logic [COLW-1:0]     col_idx;
    logic [KEY_BITS-1:0] acc, hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (irq) state_nx = S_DISCHARGE;                 // T_START
            S_DISCHARGE: if (cnt == DISCH_LAST) state_nx = S_SETTLE;      // T_SETTLE
            S_SETTLE:    if (cnt == SETTLE_LAST) state_nx = S_SAMPLE;     // T_SAMPLE
            S_SAMPLE:    state_nx = (col_idx == COL_LAST) ? S_FINISH      // T_LAST_COL
                                                          : S_DISCHARGE;  // T_NEXT_COL
            S_FINISH:    state_nx = S_IDLE;                               // T_RETURN
            default:     state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        col_level    = '0;
        col_pushpull = 1'b0;
        unique case (state)
            S_IDLE, S_FINISH: ;
            S_DISCHARGE: begin
                col_level    = '1;
                col_pushpull = 1'b1;
            end
            S_SETTLE, S_SAMPLE: col_level = ~(NUM_COLS'(1) << col_idx);
            default: ;
        endcase
    end

    assign scan_start  = (state == S_IDLE) && irq;
    assign scan_end    = (state == S_FINISH);
    assign idle        = (state == S_IDLE);
    assign arm_release = |code_q;

    // key positions hit in the current column
    always_comb begin
        hit = '0;
        for (int c = 0; c < NUM_COLS; c++)
            for (int r = 0; r < NUM_ROWS; r++)
                if (r < keys_in_col(c) && int'(col_idx) == c && !row_sync[r])
                    hit[col_base(c) + r] = 1'b1;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            col_idx   <= '0;
            acc       <= '0;
            code_q    <= '0;
            scan_done <= 1'b0;
        end else begin
            scan_done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    cnt     <= '0;
                    col_idx <= '0;
                    acc     <= '0;
                end
                S_DISCHARGE: cnt <= (cnt == DISCH_LAST) ? '0 : cnt + 1'b1;
                S_SETTLE:    cnt <= (cnt == SETTLE_LAST) ? '0 : cnt + 1'b1;
                S_SAMPLE: begin
                    acc <= acc | hit;
                    if (col_idx != COL_LAST) col_idx <= col_idx + 1'b1;
                end
                S_FINISH: begin
                    code_q    <= acc;
                    scan_done <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/keyscan_csr.sv
module keyscan_csr
    import keyscan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ROWS-1:0] row_sync,
    input  logic                idle,
    input  logic                scan_start,
    input  logic                scan_end,
    input  logic                arm_release,
    input  logic                csr_we,
    input  logic [CSR_W-1:0]    csr_wdata,
    output logic [CSR_W-1:0]    csr_rdata,
    output logic                irq
);
    localparam logic [2:0] CHAIN_PRESET = 3'b011;

    logic [2:0] dep_ch, rel_ch;
    logic dep_flag, rel_flag, dep_en, rel_en;
    logic any_low, all_high;
    logic unused_wbits;

    assign unused_wbits = ^csr_wdata[7:4];
    assign any_low  = idle && !(&row_sync);
    assign all_high = idle && (&row_sync);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dep_ch   <= '0;
            rel_ch   <= CHAIN_PRESET;
            dep_flag <= 1'b0;
            rel_flag <= 1'b0;
            dep_en   <= 1'b1;
            rel_en   <= 1'b1;
        end else begin
            dep_ch <= {dep_ch[1:0], any_low};
            rel_ch <= {rel_ch[1:0], all_high};
            if (dep_ch[1] && !dep_ch[2]) dep_flag <= 1'b1;
            if (rel_ch[1] && !rel_ch[2]) rel_flag <= 1'b1;
            if (csr_we) begin
                if (csr_wdata[B_DEP_FLAG]) dep_flag <= 1'b0;
                if (csr_wdata[B_REL_FLAG]) rel_flag <= 1'b0;
                if (csr_wdata[B_DEP_CLR])  dep_ch   <= '0;
                if (csr_wdata[B_REL_SET])  rel_ch   <= CHAIN_PRESET;
                dep_en <= csr_wdata[B_DEP_EN];
                rel_en <= csr_wdata[B_REL_EN];
            end
            if (scan_start) begin
                dep_en <= 1'b0;
                rel_en <= 1'b0;
            end
            if (scan_end) begin
                dep_flag <= 1'b0;
                rel_flag <= 1'b0;
                dep_ch   <= '0;
                rel_ch   <= CHAIN_PRESET;
                dep_en   <= !arm_release;
                rel_en   <= arm_release;
            end
        end
    end

    always_comb begin
        csr_rdata             = '0;
        csr_rdata[B_DEP_FLAG] = dep_flag;
        csr_rdata[B_REL_FLAG] = rel_flag;
        csr_rdata[B_DEP_EN]   = dep_en;
        csr_rdata[B_REL_EN]   = rel_en;
    end

    assign irq = (dep_flag && dep_en) || (rel_flag && rel_en);
endmodule

// File: rtl/keyscan_ctrl.sv
module keyscan_ctrl
    import keyscan_pkg::*;
#(
    parameter int DISCH_CYC  = 256,
    parameter int SETTLE_CYC = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ROWS-1:0] row_n_i,
    input  logic                hold_i,
    input  logic                csr_we_i,
    input  logic [CSR_W-1:0]    csr_wdata_i,
    output logic [CSR_W-1:0]    csr_rdata_o,
    output logic [NUM_COLS-1:0] col_level_o,
    output logic                col_pushpull_o,
    output logic [KEY_BITS-1:0] key_code_o,
    output logic                scan_done_o,
    output logic                irq_o
);
    logic [NUM_ROWS-1:0] row_sync;
    logic [KEY_BITS-1:0] code_q;
    logic scan_start, scan_end, arm_release, idle;

    keyscan_rowsync #(.W(NUM_ROWS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (row_n_i),
        .sync_o  (row_sync)
    );

    keyscan_seq #(.DISCH_CYC(DISCH_CYC), .SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .row_sync     (row_sync),
        .irq          (irq_o),
        .col_level    (col_level_o),
        .col_pushpull (col_pushpull_o),
        .code_q       (code_q),
        .scan_start   (scan_start),
        .scan_end     (scan_end),
        .arm_release  (arm_release),
        .idle         (idle),
        .scan_done    (scan_done_o)
    );

    keyscan_csr u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_sync    (row_sync),
        .idle        (idle),
        .scan_start  (scan_start),
        .scan_end    (scan_end),
        .arm_release (arm_release),
        .csr_we      (csr_we_i),
        .csr_wdata   (csr_wdata_i),
        .csr_rdata   (csr_rdata_o),
        .irq         (irq_o)
    );

    assign key_code_o = hold_i ? '0 : code_q;
endmodule

// File: rtl/keyscan_ctrl_chk.sv
module keyscan_ctrl_chk
    import keyscan_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                hold_i,
    input logic [CSR_W-1:0]    csr_rdata_o,
    input logic [NUM_COLS-1:0] col_level_o,
    input logic                col_pushpull_o,
    input logic [KEY_BITS-1:0] key_code_o,
    input logic                scan_done_o
);
    // R2: push-pull phase always drives every column high
    p_discharge_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        col_pushpull_o |-> (col_level_o == '1));

    // R2, R5: in open-drain mode either all columns are low or exactly one is
    p_one_col_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !col_pushpull_o |-> (col_level_o == '0 || $countones(~col_level_o) == 1));

    // R11: the done strobe lasts one cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_o |=> !scan_done_o);

    // R11: the code moves only with a done strobe or a change of hold
    p_code_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_done_o && $stable(hold_i)) |-> $stable(key_code_o));

    // R5: a scan begins with both enables cleared
    p_start_clears_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_pushpull_o) |-> (csr_rdata_o[B_REL_EN:B_DEP_EN] == 2'b00));

    // R7: exactly one interrupt is armed when a scan completes
    p_arm_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_o |-> ($countones(csr_rdata_o[B_REL_EN:B_DEP_EN]) == 1));
endmodule

bind keyscan_ctrl keyscan_ctrl_chk u_chk (.*);

// File: tb/tb_keyscan_ctrl.sv
module tb_keyscan_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DISCH  = 6;
    localparam int SETTLE = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  row_n;
    logic        hold = 1'b0;
    logic        we = 1'b0;
    logic [9:0]  wdata = '0;
    logic [9:0]  rdata;
    logic [2:0]  col_level;
    logic        col_pp;
    logic [11:0] key_code;
    logic        scan_done;
    logic        irq;

    bit press [3][5];
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyscan_ctrl #(.DISCH_CYC(DISCH), .SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .row_n_i(row_n), .hold_i(hold),
        .csr_we_i(we), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
        .col_level_o(col_level), .col_pushpull_o(col_pp),
        .key_code_o(key_code), .scan_done_o(scan_done), .irq_o(irq)
    );

    // matrix: a pressed key pulls its row low when its column is low
    always_comb begin
        for (int r = 0; r < 5; r++) begin
            row_n[r] = 1'b1;
            for (int c = 0; c < 3; c++)
                if (press[c][r] && !col_level[c]) row_n[r] = 1'b0;
        end
    end

    function automatic int key_bit(input int c, input int r);
        if (c == 0) return r;
        if (c == 1) return (r < 2) ? 5 + r : -1;
        return 7 + r;
    endfunction

    function automatic logic [11:0] expect_code();
        logic [11:0] v = '0;
        for (int c = 0; c < 3; c++)
            for (int r = 0; r < 5; r++)
                if (press[c][r] && key_bit(c, r) >= 0) v[key_bit(c, r)] = 1'b1;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        int t = 0;
        @(negedge clk);
        while (!scan_done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(scan_done, "R7 scan completes", int'(scan_done), 1);
    endtask

    task automatic csr_write(input logic [9:0] v);
        @(negedge clk);
        we = 1'b1;
        wdata = v;
        @(negedge clk);
        we = 1'b0;
        wdata = '0;
    endtask

    task automatic release_all();
        for (int c = 0; c < 3; c++)
            for (int r = 0; r < 5; r++)
                press[c][r] = 1'b0;
    endtask

    // per-clock reference: hold masking, code change rule, column sequence
    logic [11:0] prev_code = '0;
    logic        prev_hold = 1'b0;
    logic        prev_pp = 1'b0;
    int          pp_run = 0;
    int          col_k = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold) chk(key_code == 0, "R9 hold masks code", int'(key_code), 0);
            if (!scan_done && hold == prev_hold)
                chk(key_code == prev_code, "R11 code changes only on done",
                    int'(key_code), int'(prev_code));
            if (col_pp) pp_run++;
            if (prev_pp && !col_pp) begin
                chk(pp_run == DISCH, "R2 discharge length", pp_run, DISCH);
                chk(col_level == ~(3'b001 << col_k), "R2 column order",
                    int'(col_level), int'(~(3'b001 << col_k)) & 7);
                col_k++;
                pp_run = 0;
            end
            if (scan_done) begin
                chk(col_k == 3, "R2 three columns per scan", col_k, 3);
                col_k = 0;
            end
            if (!col_pp && col_level == 3'b000 && !scan_done && col_k != 0) begin
                col_k = col_k;
            end
        end
        prev_code = key_code;
        prev_hold = hold;
        prev_pp   = col_pp;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            chk(1'b0, "watchdog", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int lowrun;
        release_all();
        idle_cycles(3);
        // R10, R5: reset state
        chk(key_code == 0, "R10 code zero in reset", int'(key_code), 0);
        chk(col_level == 0 && !col_pp, "R5 columns low in reset", int'(col_level), 0);
        rst_n = 1'b1;

        // R10: forced scan after reset, then R7: depress armed (previous code 0)
        wait_done();
        chk(key_code == 0, "R10 empty forced scan", int'(key_code), 0);
        chk(rdata[9:8] == 2'b01, "R7 depress armed after zero code", int'(rdata[9:8]), 1);
        idle_cycles(200);
        chk(!scan_done && col_level == 0, "R5 idle quiet", int'(col_level), 0);

        // R1, R4: single key column 0 row 2
        press[0][2] = 1'b1;
        wait_done();
        chk(key_code == 12'h004, "R1 R4 single key", int'(key_code), 'h004);
        chk(rdata[9:8] == 2'b01, "R7 first scan arms depress", int'(rdata[9:8]), 1);
        wait_done();
        chk(rdata[9:8] == 2'b10, "R7 second scan arms release", int'(rdata[9:8]), 2);

        // R2: settle phase length (one column low run)
        @(negedge clk);
        while (!(col_level == 3'b110)) @(negedge clk);
        lowrun = 0;
        while (col_level == 3'b110) begin
            lowrun++;
            @(negedge clk);
        end
        chk(lowrun == SETTLE + 1, "R2 settle length", lowrun, SETTLE + 1);

        // R3: several keys in one column, ORed with another column
        press[2][0] = 1'b1;
        press[2][4] = 1'b1;
        idle_cycles(400);
        chk(key_code == expect_code(), "R3 multi key same column", int'(key_code), int'(expect_code()));

        // R9: hold masks, release restores
        hold = 1'b1;
        idle_cycles(2);
        chk(key_code == 0, "R9 hold high", int'(key_code), 0);
        hold = 1'b0;
        idle_cycles(2);
        chk(key_code == expect_code(), "R9 hold low restores", int'(key_code), int'(expect_code()));

        // R7: release all keys
        release_all();
        idle_cycles(400);
        chk(key_code == 0, "R7 code zero after release", int'(key_code), 0);
        chk(rdata[9:8] == 2'b01, "R7 depress rearmed after release", int'(rdata[9:8]), 1);

        // R4: empty position contributes nothing
        press[1][3] = 1'b1;
        wait_done();
        chk(key_code == 0, "R4 empty position", int'(key_code), 0);
        press[1][3] = 1'b0;
        press[1][1] = 1'b1;
        idle_cycles(400);
        chk(key_code == 12'h040, "R4 column 1 row 1", int'(key_code), 'h040);
        release_all();
        idle_cycles(400);
        chk(key_code == 0 && rdata[9:8] == 2'b01, "R7 quiet again", int'(rdata), 'h100);

        // R6, R12: release flag handling with enables off
        csr_write(10'h000);
        idle_cycles(2);
        chk(rdata[1] == 1'b1, "R12 release flag from last scan", int'(rdata), 2);
        csr_write(10'h002);
        idle_cycles(10);
        chk(rdata[1] == 1'b0, "R12 no re-set while rows stay high", int'(rdata), 0);
        csr_write(10'h008);
        idle_cycles(5);
        chk(rdata == 10'h002, "R6 preset chain sets release flag", int'(rdata), 2);
        chk(!irq, "R8 flag without enable gives no irq", int'(irq), 0);
        csr_write(10'h200);
        chk(irq, "R8 release flag and enable", int'(irq), 1);
        wait_done();
        chk(rdata[9:8] == 2'b01, "R7 zero code arms depress", int'(rdata[9:8]), 1);

        // R6, R12: depress flag handling with enables off
        idle_cycles(20);
        csr_write(10'h000);
        press[2][3] = 1'b1;
        idle_cycles(10);
        chk(rdata[0] == 1'b1, "R12 depress flag on press", int'(rdata), 1);
        chk(!irq, "R8 depress flag alone", int'(irq), 0);
        csr_write(10'h001);
        idle_cycles(10);
        chk(rdata[0] == 1'b0, "R6 write one clears depress flag", int'(rdata), 0);
        csr_write(10'h004);
        idle_cycles(10);
        chk(rdata[0] == 1'b1, "R6 chain clear rearms depress", int'(rdata), 1);
        csr_write(10'h100);
        idle_cycles(400);
        chk(key_code == 12'h400, "R4 column 2 row 3", int'(key_code), 'h400);
        release_all();
        idle_cycles(400);
        chk(key_code == 0, "R7 final release", int'(key_code), 0);

        summary();
        $finish;
    end
endmodule